// File: doc/BRIEF.md
# Dual Alarm Match Interrupt Unit

This block watches a running clock, delivered in BCD as minute, hour and day-of-week values, and raises an interrupt when it reaches one of two programmed alarm times. The weekly alarm fires when the minute and the hour match its settings and its day mask has the current weekday selected. The daily alarm fires on a minute and hour match alone, on any day. The compare happens only on the cycle in which the time source strobes `min_tick`, which it does once when the minute value changes. A time that stays equal for the rest of that minute therefore cannot trigger the alarm a second time.

Each alarm has an enable bit and a sticky flag. When a match sets a flag, the active-low `irq_n` goes low, provided that alarm is enabled. `irq_n` is shared with an external periodic interrupt request, `per_irq_n`. Software writes 0 to a flag bit to clear it. The enable bits are not touched by this, so the alarm stays armed and fires again at its next matching minute. The alarm fields and control bits are written through a simple write strobe, address and data port. The time counters and the bus interface belong to neighbouring blocks.

Top module: `alarm_match_irq`

## Requirements
- R1: On a cycle with `min_tick`=1, when weekly alarm enable is set, `tm_min` equals weekly minute (address 0, data[6:0]), `tm_hour` equals weekly hour (address 1, data[5:0]) and bit `tm_wday` of the weekly day mask (address 2, data[6:0], bit n for weekday n) is 1, the weekly flag reads 1 from the next cycle.
- R2: The weekly alarm does not set its flag when the mask bit for the current weekday is 0, and a weekday value of 7 never matches.
- R3: The daily alarm (minute at address 3, hour at address 4) sets its flag one cycle after a `min_tick` whose minute and hour match, regardless of `tm_wday`.
- R4: An alarm whose enable is 0 (address 5: data[0] weekly, data[1] daily) neither sets its flag nor pulls `irq_n` low.
- R5: A write to address 6 with data[0]=0 clears the weekly flag and with data[1]=0 clears the daily flag. The enables are unchanged, and the alarm sets its flag again at the next match.
- R6: The hour is compared as the whole 6-bit field, so in 12-hour use the AM/PM bit (bit 5) must also agree.
- R7: Without `min_tick` no flag is set, even when the time equals the alarm time.
- R8: `irq_n` is 0 exactly when an enabled alarm's flag is 1 or `per_irq_n` is 0.
- R9: When a match and a clear of the same flag fall in one cycle, the flag ends up 1.
- R10: Clearing an enable while its flag is 1 keeps the flag but releases `irq_n`. Writing 1 to a flag bit at address 6 leaves that flag as it was.
- R11: After reset, both flags are 0, both enables are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Register address |
| cfg_wr_data | input | 8 | Register write data |
| min_tick | input | 1 | One-cycle strobe when the minute value changes |
| tm_min | input | 7 | Current minute, BCD |
| tm_hour | input | 6 | Current hour, BCD; bit 5 is PM in 12-hour use |
| tm_wday | input | 3 | Current day-of-week, 0 to 6 |
| per_irq_n | input | 1 | Periodic interrupt request, active low |
| wk_flag | output | 1 | Weekly alarm flag |
| dy_flag | output | 1 | Daily alarm flag |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
A minute tick that matches an alarm can arrive in the same cycle as a software write that clears that alarm's flag. These are the two functions that collide. The bench provokes the collision directly by driving the clear write and the matching tick on the same clock edge, and it expects the flag to stay set. The random phase mixes clears and ticks in the same cycles, and a bench model in which setting takes precedence judges every result.

// File: rtl/alarm_pkg.sv
// Shared constants for the dual alarm unit: register addresses and
// default field widths. Assumes a 3-bit register address space.
package alarm_pkg;
    localparam int MIN_W_DEF  = 7;
    localparam int HOUR_W_DEF = 6;
    localparam int WDAY_W_DEF = 3;
    localparam int DAYS_DEF   = 7;
    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 3;

    typedef enum logic [2:0] {
        A_WK_MIN  = 3'd0,
        A_WK_HOUR = 3'd1,
        A_WK_MASK = 3'd2,
        A_DY_MIN  = 3'd3,
        A_DY_HOUR = 3'd4,
        A_ENABLE  = 3'd5,
        A_FLAGCLR = 3'd6
    } alarm_addr_e;
endpackage

// File: rtl/alarm_regs.sv
// Alarm register bank: holds both alarm settings and enables, and
// decodes flag-clear requests. Assumes field widths fit the data bus.
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int MIN_W  = MIN_W_DEF,
    parameter int HOUR_W = HOUR_W_DEF,
    parameter int DAYS   = DAYS_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [MIN_W-1:0]  wk_min,
    output logic [HOUR_W-1:0] wk_hour,
    output logic [DAYS-1:0]   wk_mask,
    output logic [MIN_W-1:0]  dy_min,
    output logic [HOUR_W-1:0] dy_hour,
    output logic              wk_en,
    output logic              dy_en,
    output logic              wk_clr,
    output logic              dy_clr
);
    logic clr_sel;

    // Register writes, decoded by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_min  <= '0;
            wk_hour <= '0;
            wk_mask <= '0;
            dy_min  <= '0;
            dy_hour <= '0;
            wk_en   <= 1'b0;
            dy_en   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_WK_MIN:  wk_min  <= wr_data[MIN_W-1:0];
                A_WK_HOUR: wk_hour <= wr_data[HOUR_W-1:0];
                A_WK_MASK: wk_mask <= wr_data[DAYS-1:0];
                A_DY_MIN:  dy_min  <= wr_data[MIN_W-1:0];
                A_DY_HOUR: dy_hour <= wr_data[HOUR_W-1:0];
                A_ENABLE: begin
                    wk_en <= wr_data[0];
                    dy_en <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    // Flag clear strobes: a 0 written to a flag bit clears it.
    always_comb begin
        clr_sel = wr_en && (wr_addr == A_FLAGCLR);
        wk_clr  = clr_sel && !wr_data[0];
        dy_clr  = clr_sel && !wr_data[1];
    end
endmodule

// File: rtl/alarm_cmp.sv
// Alarm time comparator. Matches minute and hour on a minute tick; the
// HAS_DAY variant also requires the weekday's bit in the day mask.
// Assumes weekday values at or above DAYS never match.
module alarm_cmp #(
    parameter int  MIN_W   = 7,
    parameter int  HOUR_W  = 6,
    parameter int  WDAY_W  = 3,
    parameter int  DAYS    = 7,
    parameter bit  HAS_DAY = 1'b1
) (
    input  logic              tick,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic [MIN_W-1:0]  set_min,
    input  logic [HOUR_W-1:0] set_hour,
    input  logic [DAYS-1:0]   set_mask,
    output logic              hit
);
    localparam int SPAN = 1 << WDAY_W;

    logic day_ok;
    logic time_ok;

    generate
        if (HAS_DAY) begin : g_day
            logic [SPAN-1:0] mask_ext;
            // Widen the mask so out-of-range weekdays select a zero.
            always_comb begin
                mask_ext = '0;
                mask_ext[DAYS-1:0] = set_mask;
                day_ok = mask_ext[cur_wday];
            end
        end else begin : g_noday
            logic unused_day;
            // Daily variant: weekday and mask take no part.
            always_comb begin
                unused_day = ^{cur_wday, set_mask};
                day_ok = 1'b1;
            end
        end
    endgenerate

    // Time equality, including the AM/PM bit held in the hour field.
    always_comb begin
        time_ok = (cur_min == set_min) && (cur_hour == set_hour);
        hit     = tick && time_ok && day_ok;
    end
endmodule

// File: rtl/alarm_flag.sv
// Sticky alarm flag. Sets on an enabled hit, clears on request; a set
// in the same cycle as a clear wins. Assumes single-cycle strobes.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic en,
    input  logic clr,
    output logic flag
);
    // Flag update with set taking precedence over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit && en)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/alarm_match_irq.sv
// Dual alarm match interrupt unit: weekly and daily alarms compared on
// each minute tick, sticky flags, and a shared active-low interrupt
// merged with an external periodic request. Assumes BCD time inputs
// from a separate counter block and min_tick one cycle wide.
module alarm_match_irq
    import alarm_pkg::*;
#(
    parameter int MIN_W  = MIN_W_DEF,
    parameter int HOUR_W = HOUR_W_DEF,
    parameter int WDAY_W = WDAY_W_DEF,
    parameter int DAYS   = DAYS_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              min_tick,
    input  logic [MIN_W-1:0]  tm_min,
    input  logic [HOUR_W-1:0] tm_hour,
    input  logic [WDAY_W-1:0] tm_wday,
    input  logic              per_irq_n,
    output logic              wk_flag,
    output logic              dy_flag,
    output logic              irq_n
);
    localparam int NALARM = 2;

    logic [MIN_W-1:0]  wk_min, dy_min;
    logic [HOUR_W-1:0] wk_hour, dy_hour;
    logic [DAYS-1:0]   wk_mask;
    logic              wk_en, dy_en, wk_clr, dy_clr;

    logic [NALARM-1:0] hit_v, en_v, clr_v, flag_v;

    alarm_regs #(
        .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAYS(DAYS),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .wk_min(wk_min), .wk_hour(wk_hour), .wk_mask(wk_mask),
        .dy_min(dy_min), .dy_hour(dy_hour),
        .wk_en(wk_en), .dy_en(dy_en),
        .wk_clr(wk_clr), .dy_clr(dy_clr)
    );

    alarm_cmp #(
        .MIN_W(MIN_W), .HOUR_W(HOUR_W), .WDAY_W(WDAY_W), .DAYS(DAYS),
        .HAS_DAY(1'b1)
    ) u_cmp_wk (
        .tick(min_tick), .cur_min(tm_min), .cur_hour(tm_hour),
        .cur_wday(tm_wday), .set_min(wk_min), .set_hour(wk_hour),
        .set_mask(wk_mask), .hit(hit_v[0])
    );

    alarm_cmp #(
        .MIN_W(MIN_W), .HOUR_W(HOUR_W), .WDAY_W(WDAY_W), .DAYS(DAYS),
        .HAS_DAY(1'b0)
    ) u_cmp_dy (
        .tick(min_tick), .cur_min(tm_min), .cur_hour(tm_hour),
        .cur_wday(tm_wday), .set_min(dy_min), .set_hour(dy_hour),
        .set_mask(wk_mask), .hit(hit_v[1])
    );

    // Gather per-alarm controls into vectors for the flag array.
    always_comb begin
        en_v  = {dy_en, wk_en};
        clr_v = {dy_clr, wk_clr};
    end

    generate
        for (genvar i = 0; i < NALARM; i++) begin : g_flag
            alarm_flag u_flag (
                .clk(clk), .rst_n(rst_n),
                .hit(hit_v[i]), .en(en_v[i]), .clr(clr_v[i]),
                .flag(flag_v[i])
            );
        end
    endgenerate

    // Output merge: enabled flags and the periodic request share irq_n.
    always_comb begin
        wk_flag = flag_v[0];
        dy_flag = flag_v[1];
        irq_n   = !(|(flag_v & en_v)) && per_irq_n;
    end
endmodule

// File: rtl/alarm_match_irq_chk.sv
// Property checker for the dual alarm unit, attached by bind.
module alarm_match_irq_chk #(
    parameter int MIN_W  = 7,
    parameter int HOUR_W = 6,
    parameter int WDAY_W = 3,
    parameter int DAYS   = 7,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_wr_addr,
    input logic [DATA_W-1:0] cfg_wr_data,
    input logic              min_tick,
    input logic [MIN_W-1:0]  tm_min,
    input logic [HOUR_W-1:0] tm_hour,
    input logic [WDAY_W-1:0] tm_wday,
    input logic              per_irq_n,
    input logic              wk_flag,
    input logic              dy_flag,
    input logic              irq_n,
    input logic [MIN_W-1:0]  wk_min,
    input logic [HOUR_W-1:0] wk_hour,
    input logic [DAYS-1:0]   wk_mask,
    input logic [MIN_W-1:0]  dy_min,
    input logic [HOUR_W-1:0] dy_hour,
    input logic              wk_en,
    input logic              dy_en
);
    logic [(1<<WDAY_W)-1:0] mask_w;
    logic wk_match, dy_match, clr_wr, en_wr;

    always_comb begin
        mask_w = '0;
        mask_w[DAYS-1:0] = wk_mask;
        wk_match = min_tick && wk_en && tm_min == wk_min && tm_hour == wk_hour
                   && mask_w[tm_wday];
        dy_match = min_tick && dy_en && tm_min == dy_min && tm_hour == dy_hour;
        clr_wr   = cfg_wr_en && cfg_wr_addr == 3'd6;
        en_wr    = cfg_wr_en && cfg_wr_addr == 3'd5;
    end

    AST_WK_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wk_match |=> wk_flag);  // R1
    AST_DY_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        dy_match |=> dy_flag);  // R3
    AST_WK_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wk_flag) |-> $past(wk_en && min_tick));  // R4
    AST_DY_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dy_flag) |-> $past(dy_en && min_tick));  // R7
    AST_WK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_flag && !(clr_wr && !cfg_wr_data[0])) |=> wk_flag);  // R10
    AST_CLR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !en_wr) |=> ($stable(wk_en) && $stable(dy_en)));  // R5
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (wk_flag || dy_flag || !per_irq_n));  // R8
    AST_PER_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        !per_irq_n |-> !irq_n);  // R8
endmodule

bind alarm_match_irq alarm_match_irq_chk #(
    .MIN_W(MIN_W), .HOUR_W(HOUR_W), .WDAY_W(WDAY_W),
    .DAYS(DAYS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .min_tick(min_tick), .tm_min(tm_min), .tm_hour(tm_hour),
    .tm_wday(tm_wday), .per_irq_n(per_irq_n), .wk_flag(wk_flag),
    .dy_flag(dy_flag), .irq_n(irq_n), .wk_min(wk_min), .wk_hour(wk_hour),
    .wk_mask(wk_mask), .dy_min(dy_min), .dy_hour(dy_hour),
    .wk_en(wk_en), .dy_en(dy_en)
);

// File: tb/alarm_match_irq_bench.sv
module alarm_match_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_addr = '0;
    logic [7:0] cfg_wr_data = '0;
    logic       min_tick = 1'b0;
    logic [6:0] tm_min = '0;
    logic [5:0] tm_hour = '0;
    logic [2:0] tm_wday = '0;
    logic       per_irq_n = 1'b1;
    logic       wk_flag, dy_flag, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench copy of what was programmed, and model flags.
    logic [6:0] m_wk_min, m_dy_min, m_wk_mask;
    logic [5:0] m_wk_hour, m_dy_hour;
    logic m_wk_en, m_dy_en, m_wk_f, m_dy_f;

    always #10 clk = ~clk;

    alarm_match_irq u_alarm_match_irq (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .min_tick(min_tick), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_wday(tm_wday), .per_irq_n(per_irq_n), .wk_flag(wk_flag),
        .dy_flag(dy_flag), .irq_n(irq_n)
    );

    function automatic bit wk_hit(logic [6:0] mi, logic [5:0] hr, logic [2:0] wd);
        return mi == m_wk_min && hr == m_wk_hour && wd < 3'd7 && m_wk_mask[wd];
    endfunction

    function automatic bit dy_hit(logic [6:0] mi, logic [5:0] hr);
        return mi == m_dy_min && hr == m_dy_hour;
    endfunction

    function automatic logic exp_irq();
        return !((m_wk_f && m_wk_en) || (m_dy_f && m_dy_en) || !per_irq_n);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, wk_flag, m_wk_f);
        chk(req, dy_flag, m_dy_f);
        chk(req, irq_n, exp_irq());
    endtask

    // One cycle: optional write and optional tick on the same edge.
    task automatic cyc(bit we, logic [2:0] a, logic [7:0] d,
                       bit tk, logic [6:0] mi, logic [5:0] hr, logic [2:0] wd);
        bit wh, dh, wc, dc;
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_addr = a; cfg_wr_data = d;
        min_tick = tk; tm_min = mi; tm_hour = hr; tm_wday = wd;
        wh = tk && m_wk_en && wk_hit(mi, hr, wd);
        dh = tk && m_dy_en && dy_hit(mi, hr);
        wc = we && a == 3'd6 && !d[0];
        dc = we && a == 3'd6 && !d[1];
        m_wk_f = wh ? 1'b1 : (wc ? 1'b0 : m_wk_f);
        m_dy_f = dh ? 1'b1 : (dc ? 1'b0 : m_dy_f);
        if (we) begin
            case (a)
                3'd0: m_wk_min = d[6:0];
                3'd1: m_wk_hour = d[5:0];
                3'd2: m_wk_mask = d[6:0];
                3'd3: m_dy_min = d[6:0];
                3'd4: m_dy_hour = d[5:0];
                3'd5: begin m_wk_en = d[0]; m_dy_en = d[1]; end
                default: ;
            endcase
        end
        @(negedge clk);
        cfg_wr_en = 1'b0; min_tick = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, tm_min, tm_hour, tm_wday);
    endtask

    task automatic tick(logic [6:0] mi, logic [5:0] hr, logic [2:0] wd);
        cyc(1'b0, 3'd0, 8'd0, 1'b1, mi, hr, wd);
    endtask

    initial begin
        m_wk_min = '0; m_dy_min = '0; m_wk_mask = '0;
        m_wk_hour = '0; m_dy_hour = '0;
        m_wk_en = 0; m_dy_en = 0; m_wk_f = 0; m_dy_f = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R11");

        // R1: weekly match on Tuesday (day 2) 08:30.
        wr(3'd0, 8'h30); wr(3'd1, 8'h08); wr(3'd2, 8'b0000100);
        wr(3'd5, 8'h01);
        tick(7'h30, 6'h08, 3'd2);
        chk("R1", wk_flag, 1'b1); chk("R1", irq_n, 1'b0);
        // R5: clear keeps enable, refires next match.
        wr(3'd6, 8'h02);
        chk("R5", wk_flag, 1'b0); chk("R5", irq_n, 1'b1);
        // R7: time equal but no tick.
        cyc(1'b0, 3'd0, 8'd0, 1'b0, 7'h30, 6'h08, 3'd2);
        chk("R7", wk_flag, 1'b0);
        tick(7'h30, 6'h08, 3'd2);
        chk("R5", wk_flag, 1'b1);
        wr(3'd6, 8'h02);
        // R2: masked-out weekday and weekday 7.
        tick(7'h30, 6'h08, 3'd3);
        chk("R2", wk_flag, 1'b0);
        wr(3'd2, 8'h7F);
        tick(7'h30, 6'h08, 3'd7);
        chk("R2", wk_flag, 1'b0);
        // R6: PM bit differs.
        tick(7'h30, 6'h28, 3'd2);
        chk("R6", wk_flag, 1'b0);
        // R3: daily alarm at PM 11:59, any weekday.
        wr(3'd3, 8'h59); wr(3'd4, 8'h31); wr(3'd5, 8'h03);
        tick(7'h59, 6'h31, 3'd6);
        chk("R3", dy_flag, 1'b1); chk("R3", wk_flag, 1'b0);
        // R10: disabling masks irq but keeps flag; writing 1 keeps flag.
        wr(3'd5, 8'h01);
        chk("R10", dy_flag, 1'b1); chk("R10", irq_n, 1'b1);
        wr(3'd6, 8'h03);
        chk("R10", dy_flag, 1'b1);
        wr(3'd6, 8'h01);
        chk("R10", dy_flag, 1'b0);
        // R4: disabled daily alarm does not set.
        tick(7'h59, 6'h31, 3'd1);
        chk("R4", dy_flag, 1'b0); chk("R4", irq_n, 1'b1);
        // R9: match and clear in the same cycle.
        cyc(1'b1, 3'd6, 8'h00, 1'b1, 7'h30, 6'h08, 3'd2);
        chk("R9", wk_flag, 1'b1);
        wr(3'd6, 8'h00);
        // R8: periodic request passes through.
        per_irq_n = 1'b0;
        @(negedge clk);
        chk("R8", irq_n, 1'b0);
        per_irq_n = 1'b1;
        @(negedge clk);
        chk("R8", irq_n, 1'b1);

        // Random phase with fixed seed.
        void'($urandom(32'h5EED_0A1A));
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [6:0] mi;
            logic [5:0] hr;
            logic [2:0] wd;
            op = int'($urandom_range(0, 9));
            mi = 7'($urandom_range(0, 3)); hr = 6'($urandom_range(0, 3));
            wd = 3'($urandom_range(0, 7));
            per_irq_n = ($urandom_range(0, 7) != 0);
            if (op < 3)
                wr(3'($urandom_range(0, 5)), 8'($urandom));
            else if (op < 5)
                cyc(1'b1, 3'd6, 8'($urandom_range(0, 3)),
                    1'b1, mi, hr, wd);
            else if (op < 7)
                tick(m_wk_min, m_wk_hour, wd);
            else
                tick(m_dy_min, m_dy_hour, wd);
            chk_all("R8 random R9");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule